// File: doc/BRIEF.md
# Little-Endian Byte/Word Memory Access Unit

This block sits between a 16-bit register datapath and a store of 16-bit words. A client issues requests with byte addresses. Each request asks for a 16-bit word or a single byte, to be read or written. The unit works out which word is meant and which byte lanes are involved. It drives a word-indexed memory through a two-bit lane write enable and returns read data one cycle later. Byte reads come back zero-extended. Word accesses at an odd byte address are refused and flagged.

The byte order is little-endian. A word's address is the byte address of its less significant byte, so neighbouring words lie two byte addresses apart. Byte address bit 0 picks the lane, where 0 is bits [7:0] and 1 is bits [15:8]. The remaining upper address bits index the word.

The unit accepts a request on every cycle and has no back-pressure. A small state machine records the outcome of the previous cycle's request. It has three states. ST_IDLE means no response is pending. ST_READ_DONE means read data is being presented. ST_FAULT means a misaligned word access is being reported. All transitions are taken every cycle from any state, according to the incoming request:
- T_NONE: no valid request leads to ST_IDLE.
- T_WRITE: an accepted aligned or byte write leads to ST_IDLE.
- T_READ: an accepted aligned or byte read leads to ST_READ_DONE.
- T_MISALIGN: a word access with address bit 0 set leads to ST_FAULT.

Top module: `bwm_access`

## Requirements
- R1: After reset, rsp_valid and rsp_err are both 0.
- R2: A word write (req_size=1, even address) stores all 16 bits of req_wdata. A later word read of that address returns them on rsp_rdata, with rsp_valid high in the cycle after the read is accepted.
- R3: Lane mapping is little-endian. In the word at even byte address A, byte address A holds bits [7:0] and byte address A+1 holds bits [15:8].
- R4: A byte read (req_size=0) returns the addressed byte in rsp_rdata[7:0], with rsp_rdata[15:8] equal to 0.
- R5: A byte write stores only req_wdata[7:0] into the addressed byte. The other byte of that word is left unchanged, and req_wdata[15:8] has no effect.
- R6: A word access (read or write) with address bit 0 set gives rsp_err=1 and rsp_valid=0 in the next cycle, and changes no memory contents.
- R7: Writes and idle cycles produce no response: in the following cycle rsp_valid=0 and rsp_err=0.
- R8: Requests may arrive on consecutive cycles. Each read's data appears in the cycle after that read, regardless of its neighbours.
- R9: rsp_valid and rsp_err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted every cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data from the register |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 16 | Read data (byte reads zero-extended); 0 when not valid |
| rsp_err | output | 1 | Misaligned word access reported |

## Verification
The assertions watch the response timing and kind on every cycle:
- a read yields rsp_valid one cycle later;
- a misaligned word access yields rsp_err without rsp_valid;
- writes and idle cycles stay silent;
- the upper byte of a byte read is zero;
- the two response flags are never high together.

Stored contents cannot be checked cycle by cycle. The bench scenarios cover them by reading words and bytes back after writes:
- the little-endian lane mapping;
- byte writes that leave the neighbouring byte intact;
- the absence of a write after a refused misaligned access.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int LANES   = WORD_W / BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_DONE = 2'd1,
        ST_FAULT     = 2'd2
    } bwm_state_e;

    typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/bwm_decode.sv
module bwm_decode
    import bwm_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int IDX_W = ADDR_W - 1
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic              size_word,
    input  logic              write,
    input  logic [WORD_W-1:0] wdata,
    output logic [IDX_W-1:0]  word_idx,
    output logic              lane_hi,
    output logic              misaligned,
    output lane_mask_t        lane_we,
    output logic              rd_en,
    output logic [WORD_W-1:0] lane_wdata
);
    assign word_idx   = addr[ADDR_W-1:1];
    assign lane_hi    = addr[0];
    assign misaligned = valid && size_word && addr[0];
    assign rd_en      = valid && !write && !misaligned;

    always_comb begin
        lane_we    = '0;
        lane_wdata = wdata;
        if (!size_word) begin
            lane_wdata = {wdata[BYTE_W-1:0], wdata[BYTE_W-1:0]};
        end
        if (valid && write && !misaligned) begin
            if (size_word) begin
                lane_we = '1;
            end else begin
                lane_we = addr[0] ? lane_mask_t'(2'b10) : lane_mask_t'(2'b01);
            end
        end
    end
endmodule

// File: rtl/bwm_store.sv
module bwm_store
    import bwm_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int DEPTH = 2 ** IDX_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  word_idx,
    input  lane_mask_t        lane_we,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] bank [DEPTH];
        logic [BYTE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                bank[word_idx] <= wdata[g*BYTE_W +: BYTE_W];
            end
            if (rd_en) begin
                rd_q <= bank[word_idx];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = rd_q;
    end
endmodule

// File: rtl/bwm_format.sv
module bwm_format
    import bwm_pkg::*;
(
    input  logic              size_word,
    input  logic              lane_hi,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] result
);
    always_comb begin
        if (size_word) begin
            result = word;
        end else if (lane_hi) begin
            result = {{(WORD_W-BYTE_W){1'b0}}, word[WORD_W-1:BYTE_W]};
        end else begin
            result = {{(WORD_W-BYTE_W){1'b0}}, word[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/bwm_access.sv
module bwm_access
    import bwm_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0]  word_idx;
    logic              lane_hi;
    logic              misaligned;
    lane_mask_t        lane_we;
    logic              rd_en;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] store_rdata;
    logic [WORD_W-1:0] fmt_data;

    bwm_state_e state_q, state_d;
    logic       rd_size_q;
    logic       rd_lane_q;

    bwm_decode #(.ADDR_W(ADDR_W)) u_decode (
        .valid      (req_valid),
        .addr       (req_addr),
        .size_word  (req_size),
        .write      (req_write),
        .wdata      (req_wdata),
        .word_idx   (word_idx),
        .lane_hi    (lane_hi),
        .misaligned (misaligned),
        .lane_we    (lane_we),
        .rd_en      (rd_en),
        .lane_wdata (lane_wdata)
    );

    bwm_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .word_idx (word_idx),
        .lane_we  (lane_we),
        .rd_en    (rd_en),
        .wdata    (lane_wdata),
        .rdata    (store_rdata)
    );

    bwm_format u_format (
        .size_word (rd_size_q),
        .lane_hi   (rd_lane_q),
        .word      (store_rdata),
        .result    (fmt_data)
    );

    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;          // T_NONE
        end else if (misaligned) begin
            state_d = ST_FAULT;         // T_MISALIGN
        end else if (!req_write) begin
            state_d = ST_READ_DONE;     // T_READ
        end else begin
            state_d = ST_IDLE;          // T_WRITE
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_size_q <= 1'b0;
            rd_lane_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_en) begin
                rd_size_q <= req_size;
                rd_lane_q <= lane_hi;
            end
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ_DONE: begin
                rsp_valid = 1'b1;
                rsp_rdata = fmt_data;
            end
            ST_FAULT: rsp_err = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/bwm_access_chk.sv
module bwm_access_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        addr_lsb,
    input logic        req_size,
    input logic        req_write,
    input logic        rsp_valid,
    input logic [15:0] rsp_rdata,
    input logic        rsp_err
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && rsp_err)); // R9

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !(req_size && addr_lsb)) |=> rsp_valid); // R2

    AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size && addr_lsb) |=> (rsp_err && !rsp_valid)); // R6

    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !(req_size && addr_lsb)) |=> (!rsp_valid && !rsp_err)); // R7

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err)); // R7

    AST_BYTE_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_size) |=> (rsp_rdata[15:8] == 8'h00)); // R4
endmodule

bind bwm_access bwm_access_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .addr_lsb  (req_addr[0]),
    .req_size  (req_size),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/bwm_access_tb_top.sv
module bwm_access_tb_top;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_size = 1'b0;
    logic              req_write = 1'b0;
    logic [15:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [15:0]       rsp_rdata;
    logic              rsp_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        s_valid;
    logic        s_err;
    logic [15:0] s_data;

    always #2.5 clk = ~clk;

    bwm_access #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(bit wr, bit word, int addr, logic [15:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_size  = word;
        req_addr  = ADDR_W'(addr);
        req_wdata = d;
    endtask

    // one request, then sample the response in the following cycle
    task automatic one(bit wr, bit word, int addr, logic [15:0] d);
        @(negedge clk);
        drive(wr, word, addr, d);
        @(negedge clk);
        req_valid = 1'b0;
        s_valid = rsp_valid;
        s_err   = rsp_err;
        s_data  = rsp_rdata;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid", 16'(rsp_valid), 16'h0);
        chk("R1 err", 16'(rsp_err), 16'h0);
    endtask

    task automatic t_word();
        one(1, 1, 4, 16'hA55A);
        one(0, 1, 4, 16'h0);
        chk("R2 valid", 16'(s_valid), 16'h1);
        chk("R2 data", s_data, 16'hA55A);
    endtask

    task automatic t_lanes();
        one(1, 1, 6, 16'h1234);
        one(0, 0, 6, 16'h0);
        chk("R3 low lane", s_data, 16'h0034);
        one(0, 0, 7, 16'h0);
        chk("R3 high lane", s_data, 16'h0012);
        chk("R4 valid", 16'(s_valid), 16'h1);
        one(1, 1, 20, 16'hFFEE);
        one(0, 0, 21, 16'h0);
        chk("R4 zero fill", s_data, 16'h00FF);
    endtask

    task automatic t_byte_write();
        one(1, 0, 7, 16'hFFAB);
        one(0, 1, 6, 16'h0);
        chk("R5 high byte", s_data, 16'hAB34);
        one(1, 0, 6, 16'h77CD);
        one(0, 1, 6, 16'h0);
        chk("R5 low byte", s_data, 16'hABCD);
    endtask

    task automatic t_misalign();
        one(1, 1, 8, 16'h1111);
        one(1, 1, 9, 16'hBEEF);
        chk("R6 write err", 16'(s_err), 16'h1);
        chk("R6 write no valid", 16'(s_valid), 16'h0);
        one(0, 1, 8, 16'h0);
        chk("R6 no store", s_data, 16'h1111);
        one(0, 0, 9, 16'h0);
        chk("R6 high byte intact", s_data, 16'h0011);
        one(0, 1, 9, 16'h0);
        chk("R6 read err", 16'(s_err), 16'h1);
        chk("R6 read no valid", 16'(s_valid), 16'h0);
    endtask

    task automatic t_silent();
        one(1, 1, 30, 16'h5555);
        chk("R7 write valid", 16'(s_valid), 16'h0);
        chk("R7 write err", 16'(s_err), 16'h0);
        @(negedge clk);
        chk("R7 idle valid", 16'(rsp_valid), 16'h0);
        chk("R7 idle err", 16'(rsp_err), 16'h0);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        drive(1, 1, 10, 16'h0A0A);
        @(negedge clk);
        drive(1, 1, 12, 16'h0C0C);
        @(negedge clk);
        drive(0, 1, 10, 16'h0);
        @(negedge clk);
        drive(0, 0, 13, 16'h0);
        chk("R8 first read", rsp_rdata, 16'h0A0A);
        @(negedge clk);
        drive(0, 1, 12, 16'h0);
        chk("R8 second read", rsp_rdata, 16'h000C);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 third read", rsp_rdata, 16'h0C0C);
        chk("R8 valid", 16'(rsp_valid), 16'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word();
        t_lanes();
        t_byte_write();
        t_misalign();
        t_silent();
        t_b2b();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule